// File: doc/BRIEF.md
# DMA Channel Hardware-Trigger Controller

This block decides when a single DMA channel starts a transaction and when it issues each transfer inside it, based on sixteen hardware trigger lines. Software programs a small register set: the trigger line select, two mode bits, a reload count, source and destination base addresses, and a signed step for each address. Software then arms the channel by setting its request-enable flag. A rising edge on the selected trigger line starts the work. The controller presents each transfer to a data mover as a request carrying the source and destination addresses, and it advances its state whenever the mover acknowledges.

The two mode bits set the trigger behaviour. The continuous bit chooses whether hardware disarms the channel when a transaction ends, so that software can reprogram it before the next one. The whole-transaction bit chooses whether one trigger runs every transfer back to back or runs only one transfer. At the end of every transaction a one-cycle done pulse is raised.

Top module: `dmahw_channel`

## Requirements
- R1: Only line `hw_req[sel]` can trigger the channel, where `sel` is control register bits [7:4]. Edges on every other line have no effect.
- R2: The request-enable flag `req_en` is clear after reset. A write to register 6 with data bit 0 set sets the flag. While the flag is clear, a trigger starts nothing and `xfer_req` stays low.
- R3: A trigger is a rising edge of the selected line while the channel is idle. If the line is driven high before clock edge k, `xfer_req` is high after edge k+1. For a new transaction, `xfer_left` then holds the reload value (register 1) and the addresses equal the bases.
- R4: Each acknowledged transfer (`xfer_req` and `xfer_ack` high at a clock edge) decrements `xfer_left` by one. A transaction ends when `xfer_left` reaches zero.
- R5: With control bit 0 (continuous) clear, the end of a transaction clears both `chan_active` and `req_en`. Triggers are then ignored until software sets the enable again.
- R6: With control bit 0 set, `req_en` stays set at the end of a transaction, and the next trigger starts a new transaction with the counter and addresses reloaded.
- R7: With control bit 1 (whole-transaction) set, one trigger issues every transfer of the transaction back to back, one per acknowledge.
- R8: With control bit 1 clear, `xfer_req` drops after each acknowledged transfer. Each further transfer of the same transaction needs a new trigger.
- R9: A trigger line held high starts only one transfer. Another trigger needs the line to go low and then high again.
- R10: After each acknowledged transfer, the source and destination addresses each advance by their own signed 16-bit step (register 4 for the source, register 5 for the destination). Registers 2 and 3 hold the bases, which are loaded when a transaction starts.
- R11: A reload value of zero gives a transaction of exactly one transfer.
- R12: `txn_done` is high for exactly one cycle, the cycle after the final acknowledge, in both continuous and single mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register index: 0 control, 1 reload, 2 source base, 3 destination base, 4 source step, 5 destination step, 6 enable set |
| cfg_wdata | input | 32 | Register write data |
| hw_req | input | 16 | Hardware trigger lines |
| xfer_ack | input | 1 | Data mover accepts the current transfer |
| xfer_req | output | 1 | Transfer requested from the data mover |
| xfer_src | output | 32 | Source address of the current transfer |
| xfer_dst | output | 32 | Destination address of the current transfer |
| req_en | output | 1 | Hardware request enable flag |
| chan_active | output | 1 | Channel is executing a transfer |
| txn_done | output | 1 | One-cycle pulse at the end of a transaction |
| xfer_left | output | 8 | Transfers remaining in the current transaction |

## Verification
The assertions assume that software leaves the mode bits, select and steps alone while a transaction is in progress. They also assume that the data mover acknowledges only while a request is pending. The stimulus writes configuration only after the previous transaction has completed. It finishes every started transaction, in per-transfer mode by supplying the remaining triggers. The acknowledge is formed from `xfer_req` gated by a stall pattern, so it is never high without a pending request.

// File: rtl/dmahw_pkg.sv
package dmahw_pkg;
    localparam int REGA_W     = 3;
    localparam int REG_CTRL   = 0;
    localparam int REG_RELOAD = 1;
    localparam int REG_SRC    = 2;
    localparam int REG_DST    = 3;
    localparam int REG_SSTEP  = 4;
    localparam int REG_DSTEP  = 5;
    localparam int REG_ENSET  = 6;

    localparam int CTRL_CONT_BIT = 0;
    localparam int CTRL_WHOLE_BIT = 1;
    localparam int CTRL_SEL_LSB  = 4;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_XFER = 1'b1
    } chan_state_e;
endpackage

// File: rtl/dmahw_cfg_regs.sv
module dmahw_cfg_regs
    import dmahw_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 8,
    parameter int STEP_W = 16,
    parameter int SEL_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REGA_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              cont_mode,
    output logic              whole_txn,
    output logic [SEL_W-1:0]  sel,
    output logic [CNT_W-1:0]  reload,
    output logic [ADDR_W-1:0] src_base,
    output logic [ADDR_W-1:0] dst_base,
    output logic [STEP_W-1:0] src_step,
    output logic [STEP_W-1:0] dst_step,
    output logic              en_set
);
    typedef struct packed {
        logic              cont;
        logic              whole;
        logic [SEL_W-1:0]  sel;
        logic [CNT_W-1:0]  reload;
        logic [ADDR_W-1:0] src_base;
        logic [ADDR_W-1:0] dst_base;
        logic [STEP_W-1:0] src_step;
        logic [STEP_W-1:0] dst_step;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            case (int'(wr_addr))
                REG_CTRL: begin
                    cfg_d.cont  = wr_data[CTRL_CONT_BIT];
                    cfg_d.whole = wr_data[CTRL_WHOLE_BIT];
                    cfg_d.sel   = wr_data[CTRL_SEL_LSB +: SEL_W];
                end
                REG_RELOAD: cfg_d.reload   = wr_data[CNT_W-1:0];
                REG_SRC:    cfg_d.src_base = wr_data[ADDR_W-1:0];
                REG_DST:    cfg_d.dst_base = wr_data[ADDR_W-1:0];
                REG_SSTEP:  cfg_d.src_step = wr_data[STEP_W-1:0];
                REG_DSTEP:  cfg_d.dst_step = wr_data[STEP_W-1:0];
                default:    cfg_d = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign en_set    = wr_en && (int'(wr_addr) == REG_ENSET) && wr_data[0];
    assign cont_mode = cfg_q.cont;
    assign whole_txn = cfg_q.whole;
    assign sel       = cfg_q.sel;
    assign reload    = cfg_q.reload;
    assign src_base  = cfg_q.src_base;
    assign dst_base  = cfg_q.dst_base;
    assign src_step  = cfg_q.src_step;
    assign dst_step  = cfg_q.dst_step;
endmodule

// File: rtl/dmahw_req_detect.sv
module dmahw_req_detect #(
    parameter int N_LINES = 16,
    parameter int SEL_W   = $clog2(N_LINES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] lines,
    input  logic [SEL_W-1:0]   sel,
    output logic               rise
);
    typedef struct packed {
        logic cur;
        logic prev;
    } edge_t;

    edge_t edge_d, edge_q;

    always_comb begin
        edge_d      = edge_q;
        edge_d.cur  = lines[sel];
        edge_d.prev = edge_q.cur;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_q <= '0;
        end else begin
            edge_q <= edge_d;
        end
    end

    assign rise = edge_q.cur && !edge_q.prev;
endmodule

// File: rtl/dmahw_addr_step.sv
module dmahw_addr_step #(
    parameter int ADDR_W = 32,
    parameter int STEP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              advance,
    input  logic [ADDR_W-1:0] base,
    input  logic [STEP_W-1:0] step,
    output logic [ADDR_W-1:0] addr
);
    localparam int EXT_W = ADDR_W - STEP_W;

    logic [ADDR_W-1:0] addr_d, addr_q;
    logic [ADDR_W-1:0] step_ext;

    assign step_ext = {{EXT_W{step[STEP_W-1]}}, step};

    always_comb begin
        addr_d = addr_q;
        if (load) begin
            addr_d = base;
        end else if (advance) begin
            addr_d = addr_q + step_ext;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else begin
            addr_q <= addr_d;
        end
    end

    assign addr = addr_q;
endmodule

// File: rtl/dmahw_channel.sv
module dmahw_channel
    import dmahw_pkg::*;
#(
    parameter int N_LINES = 16,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 32,
    parameter int CNT_W   = 8,
    parameter int STEP_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [REGA_W-1:0]  cfg_addr,
    input  logic [DATA_W-1:0]  cfg_wdata,
    input  logic [N_LINES-1:0] hw_req,
    input  logic               xfer_ack,
    output logic               xfer_req,
    output logic [ADDR_W-1:0]  xfer_src,
    output logic [ADDR_W-1:0]  xfer_dst,
    output logic               req_en,
    output logic               chan_active,
    output logic               txn_done,
    output logic [CNT_W-1:0]   xfer_left
);
    localparam int SEL_W   = $clog2(N_LINES);
    localparam int N_PORTS = 2;

    logic              cfg_cont;
    logic              cfg_whole;
    logic [SEL_W-1:0]  cfg_sel;
    logic [CNT_W-1:0]  cfg_reload;
    logic [ADDR_W-1:0] cfg_src_base;
    logic [ADDR_W-1:0] cfg_dst_base;
    logic [STEP_W-1:0] cfg_src_step;
    logic [STEP_W-1:0] cfg_dst_step;
    logic              en_set;
    logic              trig_rise;
    logic              addr_load;
    logic              addr_adv;

    dmahw_cfg_regs #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W),
        .STEP_W (STEP_W),
        .SEL_W  (SEL_W)
    ) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_we),
        .wr_addr   (cfg_addr),
        .wr_data   (cfg_wdata),
        .cont_mode (cfg_cont),
        .whole_txn (cfg_whole),
        .sel       (cfg_sel),
        .reload    (cfg_reload),
        .src_base  (cfg_src_base),
        .dst_base  (cfg_dst_base),
        .src_step  (cfg_src_step),
        .dst_step  (cfg_dst_step),
        .en_set    (en_set)
    );

    dmahw_req_detect #(
        .N_LINES (N_LINES),
        .SEL_W   (SEL_W)
    ) detect_i (
        .clk   (clk),
        .rst_n (rst_n),
        .lines (hw_req),
        .sel   (cfg_sel),
        .rise  (trig_rise)
    );

    logic [ADDR_W-1:0] base_arr [N_PORTS];
    logic [STEP_W-1:0] step_arr [N_PORTS];
    logic [ADDR_W-1:0] addr_arr [N_PORTS];

    assign base_arr[0] = cfg_src_base;
    assign base_arr[1] = cfg_dst_base;
    assign step_arr[0] = cfg_src_step;
    assign step_arr[1] = cfg_dst_step;

    for (genvar p = 0; p < N_PORTS; p++) begin : g_addr
        dmahw_addr_step #(
            .ADDR_W (ADDR_W),
            .STEP_W (STEP_W)
        ) step_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (addr_load),
            .advance (addr_adv),
            .base    (base_arr[p]),
            .step    (step_arr[p]),
            .addr    (addr_arr[p])
        );
    end

    typedef struct packed {
        chan_state_e      state;
        logic             req_en;
        logic             in_txn;
        logic [CNT_W-1:0] count;
        logic             done;
    } chan_t;

    chan_t ch_d, ch_q;

    always_comb begin
        ch_d      = ch_q;
        ch_d.done = 1'b0;
        addr_load = 1'b0;
        addr_adv  = 1'b0;
        case (ch_q.state)
            ST_IDLE: begin
                if (trig_rise && ch_q.req_en) begin
                    ch_d.state = ST_XFER;
                    if (!ch_q.in_txn) begin
                        ch_d.in_txn = 1'b1;
                        ch_d.count  = (cfg_reload == '0) ? CNT_W'(1) : cfg_reload;
                        addr_load   = 1'b1;
                    end
                end
            end
            ST_XFER: begin
                if (xfer_ack) begin
                    addr_adv   = 1'b1;
                    ch_d.count = ch_q.count - CNT_W'(1);
                    if (ch_q.count == CNT_W'(1)) begin
                        ch_d.state  = ST_IDLE;
                        ch_d.in_txn = 1'b0;
                        ch_d.done   = 1'b1;
                        if (!cfg_cont) begin
                            ch_d.req_en = 1'b0;
                        end
                    end else if (!cfg_whole) begin
                        ch_d.state = ST_IDLE;
                    end
                end
            end
            default: ch_d.state = ST_IDLE;
        endcase
        if (en_set) begin
            ch_d.req_en = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch_q <= '0;
        end else begin
            ch_q <= ch_d;
        end
    end

    assign xfer_req    = (ch_q.state == ST_XFER);
    assign chan_active = (ch_q.state == ST_XFER);
    assign xfer_src    = addr_arr[0];
    assign xfer_dst    = addr_arr[1];
    assign req_en      = ch_q.req_en;
    assign txn_done    = ch_q.done;
    assign xfer_left   = ch_q.count;
endmodule

// File: rtl/dmahw_channel_chk.sv
module dmahw_channel_chk #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 8,
    parameter int STEP_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              xfer_req,
    input logic              xfer_ack,
    input logic [ADDR_W-1:0] xfer_src,
    input logic [ADDR_W-1:0] xfer_dst,
    input logic [CNT_W-1:0]  xfer_left,
    input logic              req_en,
    input logic              txn_done,
    input logic              cont_mode,
    input logic              whole_txn,
    input logic              en_set,
    input logic [STEP_W-1:0] src_step,
    input logic [STEP_W-1:0] dst_step
);
    localparam int EXT_W = ADDR_W - STEP_W;

    logic [ADDR_W-1:0] src_ext;
    logic [ADDR_W-1:0] dst_ext;
    logic              fire_more;

    assign src_ext   = {{EXT_W{src_step[STEP_W-1]}}, src_step};
    assign dst_ext   = {{EXT_W{dst_step[STEP_W-1]}}, dst_step};
    assign fire_more = xfer_req && xfer_ack && (xfer_left != CNT_W'(1));

    assert_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_en && !xfer_req) |=> !xfer_req);

    assert_count_dec_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fire_more |=> (xfer_left == $past(xfer_left) - CNT_W'(1)));

    assert_single_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_done && !cont_mode && !$past(en_set)) |-> !req_en);

    assert_cont_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_done && cont_mode) |-> req_en);

    assert_one_per_trig_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && xfer_ack && !whole_txn) |=> !xfer_req);

    assert_src_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fire_more |=> (xfer_src == $past(xfer_src) + $past(src_ext)));

    assert_dst_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fire_more |=> (xfer_dst == $past(xfer_dst) + $past(dst_ext)));

    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        txn_done |=> !txn_done);
endmodule

bind dmahw_channel dmahw_channel_chk #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .STEP_W (STEP_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .xfer_req  (xfer_req),
    .xfer_ack  (xfer_ack),
    .xfer_src  (xfer_src),
    .xfer_dst  (xfer_dst),
    .xfer_left (xfer_left),
    .req_en    (req_en),
    .txn_done  (txn_done),
    .cont_mode (cfg_cont),
    .whole_txn (cfg_whole),
    .en_set    (en_set),
    .src_step  (cfg_src_step),
    .dst_step  (cfg_dst_step)
);

// File: tb/dmahw_channel_tb_top.sv
module dmahw_channel_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [15:0] hw_req = '0;
    logic        xfer_ack;
    logic        xfer_req;
    logic [31:0] xfer_src;
    logic [31:0] xfer_dst;
    logic        req_en;
    logic        chan_active;
    logic        txn_done;
    logic [7:0]  xfer_left;

    logic        ack_allow = 1'b0;
    logic        stall_mode = 1'b0;

    int checks = 0;
    int errors = 0;
    int nlog = 0;
    int done_cnt = 0;
    logic [31:0] log_src [64];
    logic [31:0] log_dst [64];

    always #10 clk = ~clk;

    assign xfer_ack = xfer_req & ack_allow;

    dmahw_channel dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_addr    (cfg_addr),
        .cfg_wdata   (cfg_wdata),
        .hw_req      (hw_req),
        .xfer_ack    (xfer_ack),
        .xfer_req    (xfer_req),
        .xfer_src    (xfer_src),
        .xfer_dst    (xfer_dst),
        .req_en      (req_en),
        .chan_active (chan_active),
        .txn_done    (txn_done),
        .xfer_left   (xfer_left)
    );

    initial begin : ack_stub
        int cyc = 0;
        forever begin
            @(posedge clk);
            #3;
            cyc++;
            ack_allow = stall_mode ? ((cyc % 3) != 0) : 1'b1;
        end
    end

    always @(negedge clk) begin
        if (xfer_req && xfer_ack && nlog < 64) begin
            log_src[nlog] = xfer_src;
            log_dst[nlog] = xfer_dst;
            nlog++;
        end
        if (txn_done) done_cnt++;
    end

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin : watchdog
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: run did not complete, actual timeout expected completion");
        report();
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_addr = 3'(a);
        cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic setup(input bit cont, input bit whole, input int sel, input int reload,
                         input logic [31:0] sb, input logic [31:0] db,
                         input logic [15:0] ss, input logic [15:0] ds);
        wr(0, (32'(sel) << 4) | (32'(whole) << 1) | 32'(cont));
        wr(1, 32'(reload));
        wr(2, sb);
        wr(3, db);
        wr(4, {16'h0, ss});
        wr(5, {16'h0, ds});
    endtask

    task automatic enable();
        wr(6, 32'h1);
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic pulse(input int line);
        @(negedge clk);
        hw_req[line] = 1'b1;
        @(negedge clk);
        hw_req[line] = 1'b0;
    endtask

    function automatic logic [31:0] addr_at(input logic [31:0] base, input logic [15:0] st, input int i);
        return base + 32'(i) * {{16{st[15]}}, st};
    endfunction

    initial begin : stim
        int sel;
        int nexp;
        logic [31:0] sb, db;
        logic [15:0] ss, ds;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle(1);

        check(req_en == 1'b0, "R2", "reset req_en", 64'(req_en), 0);
        check(xfer_req == 1'b0, "R2", "reset xfer_req", 64'(xfer_req), 0);
        check(txn_done == 1'b0, "R12", "reset txn_done", 64'(txn_done), 0);
        check(xfer_left == 8'd0, "R4", "reset xfer_left", 64'(xfer_left), 0);

        // R2: trigger while disarmed does nothing
        setup(1'b0, 1'b1, 3, 4, 32'h100, 32'h200, 16'd4, 16'd4);
        pulse(3);
        settle(8);
        check(nlog == 0, "R2", "transfers while disarmed", 64'(nlog), 0);

        // R1: sweep every line as the select
        for (int s = 0; s < 16; s++) begin
            nlog = 0;
            done_cnt = 0;
            setup(1'b0, 1'b1, s, 2, 32'h1000 + 32'(s), 32'h2000, 16'd1, 16'd2);
            enable();
            pulse((s + 1) % 16);
            pulse((s + 15) % 16);
            settle(6);
            check(nlog == 0, "R1", "transfers from unselected line", 64'(nlog), 0);
            pulse(s);
            settle(10);
            check(nlog == 2, "R1", "transfers from selected line", 64'(nlog), 2);
            check(req_en == 1'b0, "R5", "req_en after single transaction", 64'(req_en), 0);
        end

        // R3: trigger latency and reload
        nlog = 0;
        setup(1'b0, 1'b1, 5, 3, 32'h4000, 32'h5000, 16'd8, 16'd8);
        enable();
        @(negedge clk);
        hw_req[5] = 1'b1;
        @(negedge clk);
        check(xfer_req == 1'b0, "R3", "xfer_req one edge after trigger", 64'(xfer_req), 0);
        @(negedge clk);
        hw_req[5] = 1'b0;
        check(xfer_req == 1'b1, "R3", "xfer_req two edges after trigger", 64'(xfer_req), 1);
        check(xfer_left == 8'd3, "R3", "xfer_left at start", 64'(xfer_left), 3);
        check(xfer_src == 32'h4000, "R3", "first source address", 64'(xfer_src), 64'h4000);
        settle(10);
        check(nlog == 3, "R3", "transfers in transaction", 64'(nlog), 3);

        // Mode / reload / stall sweep
        for (int cont = 0; cont < 2; cont++) begin
            for (int whole = 0; whole < 2; whole++) begin
                for (int rl = 0; rl < 6; rl++) begin
                    for (int st = 0; st < 2; st++) begin
                        sel = (rl * 5 + cont + 2 * whole) % 16;
                        sb = 32'h0001_0000 + 32'(rl * 256);
                        db = 32'h0000_0040 + 32'(cont * 64);
                        ss = 16'(4 + rl);
                        ds = 16'hFFF8 - 16'(whole);
                        nexp = (rl == 0) ? 1 : rl;
                        stall_mode = st[0];
                        nlog = 0;
                        done_cnt = 0;
                        setup(cont[0], whole[0], sel, rl, sb, db, ss, ds);
                        enable();
                        if (whole == 1) begin
                            pulse(sel);
                            settle(3 * nexp + 8);
                            check(nlog == nexp, (rl == 0) ? "R11" : "R7",
                                  "back-to-back transfer count", 64'(nlog), 64'(nexp));
                        end else begin
                            for (int k = 0; k < nexp; k++) begin
                                pulse(sel);
                                settle(8);
                                check(nlog == k + 1, "R8", "transfers after each trigger",
                                      64'(nlog), 64'(k + 1));
                                check(xfer_req == 1'b0, "R8", "xfer_req idle between triggers",
                                      64'(xfer_req), 0);
                                check(xfer_left == 8'(nexp - k - 1), "R4", "xfer_left after transfer",
                                      64'(xfer_left), 64'(nexp - k - 1));
                            end
                        end
                        check(done_cnt == 1, "R12", "done pulses", 64'(done_cnt), 1);
                        check(xfer_left == 8'd0, "R4", "xfer_left at end", 64'(xfer_left), 0);
                        for (int i = 0; i < nexp && i < nlog; i++) begin
                            check(log_src[i] == addr_at(sb, ss, i), "R10", "source address",
                                  64'(log_src[i]), 64'(addr_at(sb, ss, i)));
                            check(log_dst[i] == addr_at(db, ds, i), "R10", "destination address",
                                  64'(log_dst[i]), 64'(addr_at(db, ds, i)));
                        end
                        if (cont == 1) begin
                            check(req_en == 1'b1, "R6", "req_en kept", 64'(req_en), 1);
                            pulse(sel);
                            settle(3 * nexp + 8);
                            check(nlog > nexp, "R6", "new transaction started", 64'(nlog), 64'(nexp + 1));
                            if (nlog > nexp) begin
                                check(log_src[nexp] == sb, "R6", "source reloaded",
                                      64'(log_src[nexp]), 64'(sb));
                                check(log_dst[nexp] == db, "R6", "destination reloaded",
                                      64'(log_dst[nexp]), 64'(db));
                            end
                            if (whole == 0) begin
                                for (int k = 1; k < nexp; k++) begin
                                    pulse(sel);
                                    settle(8);
                                end
                            end
                            check(nlog == 2 * nexp, "R6", "second transaction count",
                                  64'(nlog), 64'(2 * nexp));
                            check(done_cnt == 2, "R12", "done pulses after two", 64'(done_cnt), 2);
                        end else begin
                            check(req_en == 1'b0, "R5", "req_en cleared", 64'(req_en), 0);
                            check(chan_active == 1'b0, "R5", "chan_active cleared", 64'(chan_active), 0);
                            pulse(sel);
                            settle(8);
                            check(nlog == nexp, "R5", "trigger ignored after end", 64'(nlog), 64'(nexp));
                        end
                    end
                end
            end
        end
        stall_mode = 1'b0;

        // R9: held-high line starts only one transfer
        nlog = 0;
        setup(1'b0, 1'b0, 9, 3, 32'h300, 32'h600, 16'd2, 16'd2);
        enable();
        @(negedge clk);
        hw_req[9] = 1'b1;
        settle(20);
        check(nlog == 1, "R9", "transfers while held high", 64'(nlog), 1);
        @(negedge clk);
        hw_req[9] = 1'b0;
        settle(4);
        check(nlog == 1, "R9", "transfers after release", 64'(nlog), 1);
        pulse(9);
        settle(6);
        check(nlog == 2, "R9", "transfers after new edge", 64'(nlog), 2);
        pulse(9);
        settle(6);
        check(nlog == 3, "R9", "transaction complete", 64'(nlog), 3);
        check(req_en == 1'b0, "R5", "req_en after per-transfer transaction", 64'(req_en), 0);

        report();
    end
endmodule